// File: doc/BRIEF.md
# Infrared Transceiver Select Pin Controller

This block owns the select/identification pins that run to an external infrared transceiver module. There are `NSEL` bidirectional pins plus one input-only identification pin. After reset every pin is an input, so software can read an identification code from an attached adapter. Once software turns a pin group to output, the pins carry a select pattern that configures the transceiver, for example its transmit power or receive filter.

The pattern comes from one of two sources. In manual operation the pins follow bits that software writes. In automatic operation the block keeps one pattern per operating mode of the serial port (UART, SIR, Sharp-IR and a reserved fourth code). It loads the pattern for the new mode whenever `op_mode` changes, so drivers never need to know the transceiver's control details. Pin 0 can instead be taken as a second infrared receive input. It is then never driven, and only the upper pins remain for configuration.

Access goes through a small synchronous register port. Writes take effect at the clock edge, and reads are combinational. Pad cells and the infrared modulator sit outside the block.

Top module: `irsel_ctrl`

## Requirements
- R1: While `rst_n` is low, `sel_oe` is all zero with no clock edge needed. After reset every pin is an input, and the registers at address 0 (manual bits) and address 1 (control) read back 0.
- R2: A read of address 2 returns `{id_in, sel_in}` in bits NSEL..0 and zero above. A write to address 2 changes nothing.
- R3: When bit 7 of the control register is 0, `sel_out` equals bits NSEL-1..0 of the manual register (address 0) from the cycle after the write.
- R4: Control bit 1 enables the driver of pin 0, and control bit 0 enables the drivers of all pins above pin 0. Each takes effect the cycle after the write.
- R5: When control bit 7 is 1, `sel_out` shows the stored pattern of the current mode. The pattern for mode code m sits at address 3+m, bits NSEL-1..0. The mode codes are 0 UART, 1 SIR, 2 Sharp-IR and 3 reserved.
- R6: With automatic operation on, a change of `op_mode` shows the new mode's pattern on `sel_out` one clock edge after the change. Before that edge the old value stays.
- R7: A write that sets control bit 7 while it was 0 loads the current mode's pattern, so `sel_out` shows that pattern from the cycle after the write.
- R8: While automatic operation is on and `op_mode` is unchanged, writes to the pattern registers or to the manual register leave `sel_out` unchanged. The new pattern appears only at the next mode change.
- R9: Control bit 2 turns pin 0 into a receive input. `sel_oe[0]` is then 0 whatever bit 1 says, and `rx2_out` follows `sel_in[0]`. Otherwise `rx2_out` sits at the idle level `RX_IDLE` (default 1). The upper pins are unaffected.
- R10: Every register reads back what was written in its implemented bits (control bits 7, 2, 1, 0 and pattern or manual bits NSEL-1..0), and reads 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Combinational read data |
| op_mode | input | MODE_W (2) | Current operating mode code of the serial port |
| sel_in | input | NSEL (3) | Levels seen on the bidirectional select pins |
| id_in | input | 1 | Input-only identification pin |
| sel_out | output | NSEL (3) | Values to drive on the select pins |
| sel_oe | output | NSEL (3) | Per-pin output enable for the pads |
| rx2_out | output | 1 | Second infrared receive signal taken from pin 0 |

## Verification
The bench builds the block with its defaults: three select pins, four mode codes, the receive-on-pin-0 option present and an idle level of 1. With these values every mode code, including the reserved code 3 at the highest pattern address 6, can be reached through the port. The receive reassignment can be exercised against both direction groups at once. Because each of the four patterns differs from its neighbours, a wrong pattern index or a missed reload shows up as a wrong level on a specific pin.

// File: rtl/irsel_pkg.sv
package irsel_pkg;

   // mode codes delivered on op_mode
   typedef enum logic [1:0] {
      MODE_UART  = 2'd0,
      MODE_SIR   = 2'd1,
      MODE_SHARP = 2'd2,
      MODE_RSVD  = 2'd3
   } irmode_e;

   // register addresses
   localparam int ADR_MAN  = 0;
   localparam int ADR_CTRL = 1;
   localparam int ADR_ID   = 2;
   localparam int ADR_PAT0 = 3;

   // control register bit positions
   localparam int CTL_DIRHI = 0;
   localparam int CTL_DIR0  = 1;
   localparam int CTL_RX2   = 2;
   localparam int CTL_AUTO  = 7;

endpackage

// File: rtl/irsel_regs.sv
module irsel_regs
   import irsel_pkg::*;
#(
   parameter int NSEL    = 3,
   parameter int NMODE   = 4,
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 8,
   parameter bit RX2_OPT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [DATA_W-1:0]       wdata,
   output logic [DATA_W-1:0]       rdata,
   input  logic [NSEL-1:0]         sel_in,
   input  logic                    id_in,
   output logic [NSEL-1:0]         man_bits,
   output logic                    auto_en,
   output logic                    dir0,
   output logic                    dir_hi,
   output logic                    rx2_en,
   output logic [NMODE*NSEL-1:0]   pat_flat,
   output logic                    arm_load
);

   localparam logic [ADDR_W-1:0] A_MAN  = ADDR_W'(ADR_MAN);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
   localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(ADR_ID);

   logic wr_man, wr_ctl;
   assign wr_man = we && (addr == A_MAN);
   assign wr_ctl = we && (addr == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         man_bits <= '0;
         auto_en  <= 1'b0;
         dir0     <= 1'b0;
         dir_hi   <= 1'b0;
      end else begin
         if (wr_man) man_bits <= wdata[NSEL-1:0];
         if (wr_ctl) begin
            auto_en <= wdata[CTL_AUTO];
            dir0    <= wdata[CTL_DIR0];
            dir_hi  <= wdata[CTL_DIRHI];
         end
      end
   end

   // optional reassignment of pin 0 as a receive input
   generate
      if (RX2_OPT) begin : g_rx2
         logic rx2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rx2_q <= 1'b0;
            else if (wr_ctl) rx2_q <= wdata[CTL_RX2];
         end
         assign rx2_en = rx2_q;
      end else begin : g_norx2
         assign rx2_en = 1'b0;
      end
   endgenerate

   // one pattern register per mode code
   generate
      for (genvar m = 0; m < NMODE; m++) begin : g_pat
         localparam logic [ADDR_W-1:0] A_PAT = ADDR_W'(ADR_PAT0 + m);
         logic [NSEL-1:0] pat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    pat_q <= '0;
            else if (we && addr == A_PAT)  pat_q <= wdata[NSEL-1:0];
         end
         assign pat_flat[m*NSEL +: NSEL] = pat_q;
      end
   endgenerate

   // enabling automatic mode loads the current pattern on the same edge
   assign arm_load = wr_ctl && wdata[CTL_AUTO] && !auto_en;

   always_comb begin
      rdata = '0;
      if (addr == A_MAN) begin
         rdata[NSEL-1:0] = man_bits;
      end else if (addr == A_CTRL) begin
         rdata[CTL_AUTO]  = auto_en;
         rdata[CTL_RX2]   = rx2_en;
         rdata[CTL_DIR0]  = dir0;
         rdata[CTL_DIRHI] = dir_hi;
      end else if (addr == A_ID) begin
         rdata[NSEL:0] = {id_in, sel_in};
      end else begin
         for (int m = 0; m < NMODE; m++) begin
            if (addr == ADDR_W'(ADR_PAT0 + m))
               rdata[NSEL-1:0] = pat_flat[m*NSEL +: NSEL];
         end
      end
   end

endmodule

// File: rtl/irsel_mode_lut.sv
module irsel_mode_lut #(
   parameter int NSEL   = 3,
   parameter int NMODE  = 4,
   parameter int MODE_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [MODE_W-1:0]     op_mode,
   input  logic [NMODE*NSEL-1:0] pat_flat,
   input  logic                  arm_load,
   output logic [NSEL-1:0]       auto_pat
);

   logic [MODE_W-1:0] prev_mode;
   logic [NSEL-1:0]   pick;
   logic              mode_chg;

   assign mode_chg = (op_mode != prev_mode);

   // codes beyond NMODE select an all-zero pattern
   always_comb begin
      pick = '0;
      for (int m = 0; m < NMODE; m++) begin
         if (op_mode == MODE_W'(m)) pick = pat_flat[m*NSEL +: NSEL];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_mode <= '0;
         auto_pat  <= '0;
      end else begin
         prev_mode <= op_mode;
         if (mode_chg || arm_load) auto_pat <= pick;
      end
   end

endmodule

// File: rtl/irsel_pad.sv
module irsel_pad #(
   parameter int NSEL    = 3,
   parameter bit RX_IDLE = 1'b1,
   parameter bit RX2_OPT = 1'b1
) (
   input  logic            rst_n,
   input  logic            auto_en,
   input  logic [NSEL-1:0] man_bits,
   input  logic [NSEL-1:0] auto_pat,
   input  logic            dir0,
   input  logic            dir_hi,
   input  logic            rx2_en,
   input  logic            sel_in0,
   output logic [NSEL-1:0] sel_out,
   output logic [NSEL-1:0] sel_oe,
   output logic            rx2_out
);

   assign sel_out = auto_en ? auto_pat : man_bits;

   generate
      for (genvar p = 0; p < NSEL; p++) begin : g_pin
         if (p == 0) begin : g_lo
            assign sel_oe[p] = rst_n & dir0 & ~rx2_en;
         end else begin : g_hi
            assign sel_oe[p] = rst_n & dir_hi;
         end
      end

      if (RX2_OPT) begin : g_rx
         assign rx2_out = rx2_en ? sel_in0 : RX_IDLE;
      end else begin : g_norx
         logic unused_rx;
         assign unused_rx = sel_in0 ^ rx2_en;
         assign rx2_out   = RX_IDLE;
      end
   endgenerate

endmodule

// File: rtl/irsel_ctrl.sv
module irsel_ctrl
   import irsel_pkg::*;
#(
   parameter int NSEL    = 3,
   parameter int NMODE   = 4,
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 8,
   parameter bit RX2_OPT = 1'b1,
   parameter bit RX_IDLE = 1'b1,
   localparam int MODE_W = (NMODE > 1) ? $clog2(NMODE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [MODE_W-1:0] op_mode,
   input  logic [NSEL-1:0]   sel_in,
   input  logic              id_in,
   output logic [NSEL-1:0]   sel_out,
   output logic [NSEL-1:0]   sel_oe,
   output logic              rx2_out
);

   // elaboration-time parameter checks
   generate
      if (NSEL < 2 || NSEL + 1 > DATA_W)
         $error("irsel_ctrl: NSEL out of range");
      if (DATA_W < CTL_AUTO + 1)
         $error("irsel_ctrl: DATA_W too narrow for control bits");
      if (NMODE < 2)
         $error("irsel_ctrl: NMODE must be at least 2");
      if (ADR_PAT0 + NMODE > (1 << ADDR_W))
         $error("irsel_ctrl: ADDR_W too small for pattern registers");
   endgenerate

   logic [NSEL-1:0]       man_bits, auto_pat;
   logic                  auto_en, dir0, dir_hi, rx2_en, arm_load;
   logic [NMODE*NSEL-1:0] pat_flat;

   irsel_regs #(
      .NSEL(NSEL), .NMODE(NMODE), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .RX2_OPT(RX2_OPT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .sel_in(sel_in), .id_in(id_in),
      .man_bits(man_bits), .auto_en(auto_en), .dir0(dir0), .dir_hi(dir_hi),
      .rx2_en(rx2_en), .pat_flat(pat_flat), .arm_load(arm_load)
   );

   irsel_mode_lut #(
      .NSEL(NSEL), .NMODE(NMODE), .MODE_W(MODE_W)
   ) u_lut (
      .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .pat_flat(pat_flat),
      .arm_load(arm_load), .auto_pat(auto_pat)
   );

   irsel_pad #(
      .NSEL(NSEL), .RX_IDLE(RX_IDLE), .RX2_OPT(RX2_OPT)
   ) u_pad (
      .rst_n(rst_n), .auto_en(auto_en), .man_bits(man_bits),
      .auto_pat(auto_pat), .dir0(dir0), .dir_hi(dir_hi), .rx2_en(rx2_en),
      .sel_in0(sel_in[0]), .sel_out(sel_out), .sel_oe(sel_oe),
      .rx2_out(rx2_out)
   );

endmodule

// File: rtl/irsel_chk.sv
module irsel_chk #(
   parameter int NSEL   = 3,
   parameter int NMODE  = 4,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8,
   parameter int MODE_W = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_we,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic [DATA_W-1:0]     reg_wdata,
   input logic [MODE_W-1:0]     op_mode,
   input logic [NSEL-1:0]       sel_in,
   input logic [NSEL-1:0]       sel_out,
   input logic [NSEL-1:0]       sel_oe,
   input logic                  rx2_out,
   input logic                  auto_en,
   input logic                  rx2_en,
   input logic [NMODE*NSEL-1:0] pat_flat
);

   logic [NSEL-1:0] cur_pat;
   always_comb begin
      cur_pat = '0;
      for (int m = 0; m < NMODE; m++)
         if (op_mode == MODE_W'(m)) cur_pat = pat_flat[m*NSEL +: NSEL];
   end

   // R1
   always_comb begin
      if (!rst_n) oe_in_reset_chk: assert (sel_oe == '0);
   end

   // R3
   manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && reg_addr == '0 && !auto_en |=> sel_out == $past(reg_wdata[NSEL-1:0]));

   // R6
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      auto_en && !reg_we && op_mode != $past(op_mode) |=> sel_out == $past(cur_pat));

   // R8
   hold_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we && op_mode == $past(op_mode) |=> $stable(sel_out));

   // R9
   rx2_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx2_en |-> !sel_oe[0] && rx2_out == sel_in[0]);

endmodule

bind irsel_ctrl irsel_chk #(
   .NSEL(NSEL), .NMODE(NMODE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .op_mode(op_mode), .sel_in(sel_in),
   .sel_out(sel_out), .sel_oe(sel_oe), .rx2_out(rx2_out),
   .auto_en(auto_en), .rx2_en(rx2_en), .pat_flat(pat_flat)
);

// File: tb/tb_irsel_ctrl.sv
module tb_irsel_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [1:0] op_mode = 2'd0;
   logic [2:0] sel_in = '0;
   logic       id_in = 1'b0;
   logic [2:0] sel_out, sel_oe;
   logic       rx2_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam logic [2:0] P0 = 3'b101, P1 = 3'b011, P2 = 3'b110, P3 = 3'b010;

   always #5 clk = ~clk;

   irsel_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_mode(op_mode),
      .sel_in(sel_in), .id_in(id_in), .sel_out(sel_out), .sel_oe(sel_oe),
      .rx2_out(rx2_out)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // write on one clock edge; returns at the following negedge
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      #2 chk("R1 oe during reset", {5'b0, sel_oe}, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 oe after reset", {5'b0, sel_oe}, 8'h00);
      rd(3'd0, d); chk("R1 manual reg reset", d, 8'h00);
      rd(3'd1, d); chk("R1 ctrl reg reset", d, 8'h00);
   endtask

   task automatic t_idread;
      logic [7:0] d;
      sel_in = 3'b010; id_in = 1'b1;
      rd(3'd2, d); chk("R2 id read a", d, 8'h0A);
      sel_in = 3'b101; id_in = 1'b0;
      rd(3'd2, d); chk("R2 id read b", d, 8'h05);
      wr(3'd2, 8'hFF);
      chk("R2 id write no effect on pins", {sel_oe, sel_out}, 6'b0);
      rd(3'd1, d); chk("R2 id write no effect on ctrl", d, 8'h00);
   endtask

   task automatic t_dir;
      wr(3'd1, 8'h02); chk("R4 pin0 dir", {5'b0, sel_oe}, 8'h01);
      wr(3'd1, 8'h01); chk("R4 upper dir", {5'b0, sel_oe}, 8'h06);
      wr(3'd1, 8'h03); chk("R4 both dir", {5'b0, sel_oe}, 8'h07);
   endtask

   task automatic t_manual;
      wr(3'd0, 8'h04); chk("R3 manual 100", {5'b0, sel_out}, 8'h04);
      wr(3'd0, 8'hFB); chk("R3 manual 011", {5'b0, sel_out}, 8'h03);
      wr(3'd0, 8'h01); chk("R3 manual 001", {5'b0, sel_out}, 8'h01);
   endtask

   task automatic t_auto;
      logic [7:0] d;
      wr(3'd3, {5'b0, P0}); wr(3'd4, {5'b0, P1});
      wr(3'd5, {5'b0, P2}); wr(3'd6, {5'b0, P3});
      rd(3'd6, d); chk("R10 pattern readback", d, {5'b0, P3});
      @(negedge clk); op_mode = 2'd1;            // SIR while manual
      @(negedge clk); chk("R3 mode change ignored in manual", {5'b0, sel_out}, 8'h01);
      wr(3'd1, 8'h83);
      chk("R7 enable loads SIR pattern", {5'b0, sel_out}, {5'b0, P1});
      rd(3'd1, d); chk("R10 ctrl readback", d, 8'h83);
      op_mode = 2'd2;                              // at negedge
      #1 chk("R6 old value before edge", {5'b0, sel_out}, {5'b0, P1});
      @(negedge clk); chk("R5 R6 Sharp-IR pattern", {5'b0, sel_out}, {5'b0, P2});
      op_mode = 2'd3;
      @(negedge clk); chk("R5 reserved pattern", {5'b0, sel_out}, {5'b0, P3});
      op_mode = 2'd0;
      @(negedge clk); chk("R5 UART pattern", {5'b0, sel_out}, {5'b0, P0});
   endtask

   task automatic t_hold;
      wr(3'd3, 8'h07);
      chk("R8 pattern write held", {5'b0, sel_out}, {5'b0, P0});
      wr(3'd0, 8'h06);
      @(negedge clk);
      chk("R8 manual write held", {5'b0, sel_out}, {5'b0, P0});
      op_mode = 2'd1;
      @(negedge clk); op_mode = 2'd0;
      @(negedge clk); chk("R8 new pattern at next change", {5'b0, sel_out}, 8'h07);
      wr(3'd1, 8'h03);
      chk("R3 auto off returns manual", {5'b0, sel_out}, 8'h06);
   endtask

   task automatic t_rx2;
      wr(3'd1, 8'h07);
      chk("R9 pin0 not driven", {5'b0, sel_oe}, 8'h06);
      sel_in = 3'b000; #1 chk("R9 rx2 low", {7'b0, rx2_out}, 8'h00);
      sel_in = 3'b001; #1 chk("R9 rx2 high", {7'b0, rx2_out}, 8'h01);
      wr(3'd1, 8'h03);
      sel_in = 3'b000; #1 chk("R9 rx2 idle", {7'b0, rx2_out}, 8'h01);
      chk("R9 pin0 driven again", {5'b0, sel_oe}, 8'h07);
   endtask

   task automatic t_reset_again;
      @(negedge clk); rst_n = 1'b0;
      #1 chk("R1 async oe gate", {5'b0, sel_oe}, 8'h00);
      @(negedge clk); rst_n = 1'b1;
   endtask

   initial begin
      t_reset();
      t_idread();
      t_dir();
      t_manual();
      t_auto();
      t_hold();
      t_rx2();
      t_reset_again();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule